// File: doc/BRIEF.md
# T1 Blue and Red Alarm Detector

This block sits on the receive side of a T1 line interface. It watches the raw recovered bit stream, one bit each time the bit enable is high, and keeps two alarm flags. Framing is not needed. The blue flag reports an unframed all-ones condition. The red flag reports loss of carrier.

The blue flag is decided once per fixed observation window. A window is `WIN_LEN` enables long; 4632 enables is 3 ms at 1.544 Mb/s. At the close of each window the flag is set if the window held few enough zeros, and cleared otherwise. The zero limit is chosen so that a 1e-3 bit error rate on an all-ones signal still raises the alarm. A framed all-ones signal carries far more zeros in its framing bits, so it never raises it. Between window closes the flag does not move.

The red flag rises as soon as a long run of consecutive zeros has been seen. It falls only on ones density. While the flag is high, the stream is cut into back-to-back blocks of `DENS_LEN` enables. A block that holds enough ones clears the flag at its last bit. The flag itself goes to the alarm logic of the receiver.

Top module: `t1_alarm_det`

## Requirements
- R1: While `rstN` is low, both `aisAlarm` and `losAlarm` are 0, and the window, run and block positions restart from their first bit.
- R2: `aisAlarm` changes only on the clock edge that takes the last enable of a window. Windows are back-to-back runs of `WIN_LEN` (4632) enables, counted from reset.
- R3: At a window close, `aisAlarm` becomes 1 if the window, including its last bit, held at most `AIS_MAX_ZEROS` (5) zeros; exactly 5 zeros sets it.
- R4: At a window close, `aisAlarm` becomes 0 if the window held 6 or more zeros, counting a zero on the closing bit.
- R5: `losAlarm` becomes 1 on the clock edge that takes the `LOS_ZRUN`-th (192nd) consecutive enabled zero.
- R6: Any enabled one restarts the zero run, so 191 zeros followed by a one leave `losAlarm` at 0.
- R7: While `losAlarm` is 1, enables are grouped into back-to-back blocks of `DENS_LEN` (112). The first block starts at the first enable after the flag rises. At a block's last enable the flag clears if the block held at least `DENS_MIN` (14) ones; 13 ones leave it set.
- R8: A cycle with `bitEn` low has no effect: `bitIn` is ignored and no window, run or block position advances.
- R9: The two flags are independent: a window close and a red-flag change on the same edge are both applied.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| bitEn | input | 1 | High for one cycle per received bit |
| bitIn | input | 1 | Received line bit, valid when `bitEn` is high |
| aisAlarm | output | 1 | Unframed all-ones (blue) alarm |
| losAlarm | output | 1 | Loss-of-signal (red) alarm |

## Verification
The blue-flag window close and the red-flag set can land on the same edge. The stimulus places the 192nd zero of a run exactly on the last bit of a window. That zero run also pushes the window above the zero limit. On that one edge the bench expects `aisAlarm` to fall and `losAlarm` to rise together. A per-bit reference model, written from the requirements, predicts both flags for every cycle, and the monitor compares them.

// File: rtl/t1alm_pkg.sv
package t1alm_pkg;

  // Strobes from control to datapath
  typedef struct packed {
    logic bitTick;   // an enabled bit is present this cycle
    logic winClose;  // this bit is the last of an AIS window
    logic blkRun;    // density blocks are being counted
    logic blkClose;  // this bit is the last of a density block
  } alarmStrobes_t;

  // Decisions from datapath to control, valid with bitTick
  typedef struct packed {
    logic aisQuiet;  // window zero total within the AIS limit
    logic runFull;   // zero run reaches the loss threshold on this bit
    logic densOk;    // block ones total meets the density minimum
  } alarmStatus_t;

endpackage

// File: rtl/t1alm_ctl.sv
module t1alm_ctl
  import t1alm_pkg::*;
#(
  parameter int WIN_LEN  = 4632,
  parameter int DENS_LEN = 112
) (
  input  logic          clk,
  input  logic          rstN,
  input  logic          bitEn,
  input  alarmStatus_t  status,
  output alarmStrobes_t strobes,
  output logic          aisFlag,
  output logic          losFlag
);

  localparam int WW = (WIN_LEN  > 1) ? $clog2(WIN_LEN)  : 1;
  localparam int BW = (DENS_LEN > 1) ? $clog2(DENS_LEN) : 1;
  localparam logic [WW-1:0] WIN_LAST = WW'(WIN_LEN - 1);
  localparam logic [BW-1:0] BLK_LAST = BW'(DENS_LEN - 1);

  logic [WW-1:0] winPos;
  logic [BW-1:0] blkPos;
  logic          winClose;
  logic          blkClose;

  assign winClose = bitEn && (winPos == WIN_LAST);
  assign blkClose = bitEn && losFlag && (blkPos == BLK_LAST);

  always_comb begin
    strobes.bitTick  = bitEn;
    strobes.winClose = winClose;
    strobes.blkRun   = losFlag;
    strobes.blkClose = blkClose;
  end

  // Free-running window position, advanced only by enabled bits
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      winPos <= '0;
    end else if (bitEn) begin
      if (winClose) winPos <= '0;
      else          winPos <= winPos + 1'b1;
    end
  end

  // Density block position, held at zero outside loss of signal
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      blkPos <= '0;
    end else if (!losFlag) begin
      blkPos <= '0;
    end else if (bitEn) begin
      if (blkClose) blkPos <= '0;
      else          blkPos <= blkPos + 1'b1;
    end
  end

  // Blue flag: decided only at window close
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)         aisFlag <= 1'b0;
    else if (winClose) aisFlag <= status.aisQuiet;
  end

  // Red flag: zero-run set, ones-density clear
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      losFlag <= 1'b0;
    end else if (!losFlag) begin
      if (status.runFull) losFlag <= 1'b1;
    end else if (blkClose && status.densOk) begin
      losFlag <= 1'b0;
    end
  end

endmodule

// File: rtl/t1alm_dp.sv
module t1alm_dp
  import t1alm_pkg::*;
#(
  parameter int AIS_MAX_ZEROS = 5,
  parameter int LOS_ZRUN      = 192,
  parameter int DENS_MIN      = 14
) (
  input  logic          clk,
  input  logic          rstN,
  input  logic          bitIn,
  input  alarmStrobes_t strobes,
  output alarmStatus_t  status
);

  // Zero count saturates one above the limit: only "over or not" matters
  localparam int ZSATV = AIS_MAX_ZEROS + 1;
  localparam int ZW    = $clog2(ZSATV + 1);
  localparam int RW    = $clog2(LOS_ZRUN + 1);
  localparam int OW    = $clog2(DENS_MIN + 1);

  localparam logic [ZW:0]   ZLIM = (ZW+1)'(AIS_MAX_ZEROS);
  localparam logic [ZW:0]   ZSAT = (ZW+1)'(ZSATV);
  localparam logic [RW-1:0] RTOP = RW'(LOS_ZRUN);
  localparam logic [RW-1:0] RHIT = RW'(LOS_ZRUN - 1);
  localparam logic [OW:0]   OMIN = (OW+1)'(DENS_MIN);

  logic [ZW-1:0] zeroCnt;
  logic [ZW:0]   zeroSum;
  logic [RW-1:0] runCnt;
  logic [OW-1:0] onesCnt;
  logic [OW:0]   onesSum;

  assign zeroSum = {1'b0, zeroCnt} + {{ZW{1'b0}}, ~bitIn};
  assign onesSum = {1'b0, onesCnt} + {{OW{1'b0}}, bitIn};

  always_comb begin
    status.aisQuiet = (zeroSum <= ZLIM);
    status.runFull  = strobes.bitTick && !bitIn && (runCnt >= RHIT);
    status.densOk   = (onesSum >= OMIN);
  end

  // Zeros in the current AIS window
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      zeroCnt <= '0;
    end else if (strobes.bitTick) begin
      if (strobes.winClose)   zeroCnt <= '0;
      else if (zeroSum > ZSAT) zeroCnt <= ZSAT[ZW-1:0];
      else                    zeroCnt <= zeroSum[ZW-1:0];
    end
  end

  // Consecutive zero run, saturating at the threshold
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      runCnt <= '0;
    end else if (strobes.bitTick) begin
      if (bitIn)               runCnt <= '0;
      else if (runCnt != RTOP) runCnt <= runCnt + 1'b1;
    end
  end

  // Ones in the current density block, saturating at the minimum
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      onesCnt <= '0;
    end else if (!strobes.blkRun) begin
      onesCnt <= '0;
    end else if (strobes.bitTick) begin
      if (strobes.blkClose)   onesCnt <= '0;
      else if (onesSum > OMIN) onesCnt <= OMIN[OW-1:0];
      else                    onesCnt <= onesSum[OW-1:0];
    end
  end

endmodule

// File: rtl/t1_alarm_det.sv
module t1_alarm_det
  import t1alm_pkg::*;
#(
  parameter int WIN_LEN       = 4632,
  parameter int AIS_MAX_ZEROS = 5,
  parameter int LOS_ZRUN      = 192,
  parameter int DENS_LEN      = 112,
  parameter int DENS_MIN      = 14
) (
  input  logic clk,
  input  logic rstN,
  input  logic bitEn,
  input  logic bitIn,
  output logic aisAlarm,
  output logic losAlarm
);

  alarmStrobes_t strobes;
  alarmStatus_t  status;

  t1alm_ctl #(
    .WIN_LEN (WIN_LEN),
    .DENS_LEN(DENS_LEN)
  ) uCtl (
    .clk    (clk),
    .rstN   (rstN),
    .bitEn  (bitEn),
    .status (status),
    .strobes(strobes),
    .aisFlag(aisAlarm),
    .losFlag(losAlarm)
  );

  t1alm_dp #(
    .AIS_MAX_ZEROS(AIS_MAX_ZEROS),
    .LOS_ZRUN     (LOS_ZRUN),
    .DENS_MIN     (DENS_MIN)
  ) uDp (
    .clk    (clk),
    .rstN   (rstN),
    .bitIn  (bitIn),
    .strobes(strobes),
    .status (status)
  );

endmodule

// File: rtl/t1alm_chk.sv
module t1alm_chk #(
  parameter int WIN_LEN       = 4632,
  parameter int AIS_MAX_ZEROS = 5,
  parameter int LOS_ZRUN      = 192
) (
  input logic clk,
  input logic rstN,
  input logic bitEn,
  input logic bitIn,
  input logic aisAlarm,
  input logic losAlarm
);

  logic [31:0] winCnt;
  logic [31:0] zeroTot;
  logic [31:0] runLen;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      winCnt  <= '0;
      zeroTot <= '0;
      runLen  <= '0;
    end else if (bitEn) begin
      if (winCnt == 32'(WIN_LEN - 1)) begin
        winCnt  <= '0;
        zeroTot <= '0;
      end else begin
        winCnt  <= winCnt + 1;
        zeroTot <= zeroTot + {31'd0, ~bitIn};
      end
      if (bitIn) runLen <= '0;
      else       runLen <= runLen + 1;
    end
  end

  // R1
  always @(posedge clk) begin
    if (!rstN) rst_flags_low_chk: assert (!aisAlarm && !losAlarm);
  end

  // R2
  ais_window_edge_chk: assert property (@(posedge clk) disable iff (!rstN)
    !$stable(aisAlarm) |-> $past(bitEn && (winCnt == 32'(WIN_LEN - 1))));

  // R3
  ais_set_quiet_chk: assert property (@(posedge clk) disable iff (!rstN)
    $rose(aisAlarm) |-> $past((zeroTot + {31'd0, ~bitIn}) <= 32'(AIS_MAX_ZEROS)));

  // R4
  ais_clear_noisy_chk: assert property (@(posedge clk) disable iff (!rstN)
    $fell(aisAlarm) |-> $past((zeroTot + {31'd0, ~bitIn}) > 32'(AIS_MAX_ZEROS)));

  // R5
  los_set_run_chk: assert property (@(posedge clk) disable iff (!rstN)
    $rose(losAlarm) |-> $past(bitEn && !bitIn && (runLen >= 32'(LOS_ZRUN - 1))));

  // R7
  los_clear_on_bit_chk: assert property (@(posedge clk) disable iff (!rstN)
    $fell(losAlarm) |-> $past(bitEn));

  // R8
  idle_no_change_chk: assert property (@(posedge clk) disable iff (!rstN)
    !bitEn |=> ($stable(aisAlarm) && $stable(losAlarm)));

endmodule

bind t1_alarm_det t1alm_chk #(
  .WIN_LEN      (WIN_LEN),
  .AIS_MAX_ZEROS(AIS_MAX_ZEROS),
  .LOS_ZRUN     (LOS_ZRUN)
) uChk (
  .clk     (clk),
  .rstN    (rstN),
  .bitEn   (bitEn),
  .bitIn   (bitIn),
  .aisAlarm(aisAlarm),
  .losAlarm(losAlarm)
);

// File: tb/sim_t1_alarm_det.sv
module sim_t1_alarm_det;

  localparam int WIN  = 4632;
  localparam int ZMAX = 5;
  localparam int ZRUN = 192;
  localparam int DLEN = 112;
  localparam int DMIN = 14;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic bitEn = 1'b0;
  logic bitIn = 1'b0;
  logic aisAlarm;
  logic losAlarm;

  always #5 clk = ~clk;

  t1_alarm_det #(
    .WIN_LEN(WIN), .AIS_MAX_ZEROS(ZMAX), .LOS_ZRUN(ZRUN),
    .DENS_LEN(DLEN), .DENS_MIN(DMIN)
  ) u0 (
    .clk(clk), .rstN(rstN), .bitEn(bitEn), .bitIn(bitIn),
    .aisAlarm(aisAlarm), .losAlarm(losAlarm)
  );

  typedef struct {
    logic  ais;
    logic  los;
    string tag;
  } expItem_t;

  expItem_t expQ[$];
  expItem_t cur;
  int checks = 0;
  int fails  = 0;

  // reference model state
  int  mWin = 0, mZeros = 0, mRun = 0, mBlk = 0, mOnes = 0;
  logic mAis = 1'b0, mLos = 1'b0;

  task automatic modelBit(input logic b);
    logic prevLos;
    prevLos = mLos;
    if (mWin == WIN - 1) begin
      mAis   = ((mZeros + (b ? 0 : 1)) <= ZMAX);
      mZeros = 0;
      mWin   = 0;
    end else begin
      mZeros += (b ? 0 : 1);
      mWin++;
    end
    if (b) mRun = 0; else mRun++;
    if (!prevLos) begin
      if (!b && mRun >= ZRUN) mLos = 1'b1;
      mBlk = 0; mOnes = 0;
    end else begin
      mOnes += (b ? 1 : 0);
      if (mBlk == DLEN - 1) begin
        if (mOnes >= DMIN) mLos = 1'b0;
        mBlk = 0; mOnes = 0;
      end else begin
        mBlk++;
      end
    end
  endtask

  task automatic sendBit(input logic b, input string tag);
    expItem_t it;
    @(negedge clk);
    bitEn = 1'b1;
    bitIn = b;
    modelBit(b);
    it.ais = mAis; it.los = mLos; it.tag = tag;
    expQ.push_back(it);
  endtask

  task automatic idleCycles(input int n, input string tag);
    expItem_t it;
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      bitEn = 1'b0;
      bitIn = ~bitIn;
      it.ais = mAis; it.los = mLos; it.tag = tag;
      expQ.push_back(it);
    end
  endtask

  task automatic sendRun(input logic b, input int n, input string tag);
    for (int i = 0; i < n; i++) sendBit(b, tag);
  endtask

  // one window with zeros at the listed positions
  task automatic sendWindow(input int zeroAt[], input bit gaps, input string tag);
    for (int i = 0; i < WIN; i++) begin
      logic b;
      b = 1'b1;
      foreach (zeroAt[k]) if (zeroAt[k] == i) b = 1'b0;
      sendBit(b, tag);
      if (gaps && (i % 500 == 7)) idleCycles(3, tag);
    end
  endtask

  task automatic printSummary;
    $display("%0d/%0d checks passed", checks - fails, checks);
  endtask

  // monitor: compares one expected item per driven cycle
  always begin
    @(posedge clk);
    #1;
    if (expQ.size() > 0) begin
      cur = expQ.pop_front();
      checks++;
      if (aisAlarm !== cur.ais || losAlarm !== cur.los) begin
        fails++;
        $display("FAIL %s: ais/los actual %b%b expected %b%b at %0t",
                 cur.tag, aisAlarm, losAlarm, cur.ais, cur.los, $time);
      end
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    checks++; fails++;
    $display("FAIL watchdog: actual hung expected finish");
    printSummary();
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    // R1: flags low in reset
    checks++;
    if (aisAlarm !== 1'b0 || losAlarm !== 1'b0) begin
      fails++;
      $display("FAIL R1: actual %b%b expected 00", aisAlarm, losAlarm);
    end
    rstN = 1'b1;
    idleCycles(2, "R1");

    // R3: quiet window sets the blue flag; R2 holds it until close
    sendRun(1'b1, WIN, "R3");
    // R3 boundary: exactly five zeros, one on the closing bit
    sendWindow('{100, 1000, 2000, 3000, WIN - 1}, 1'b0, "R3");
    // R4: six zeros, one on the closing bit, clears it
    sendWindow('{5, 600, 1200, 2400, 3600, WIN - 1}, 1'b0, "R4");
    // R8: idle cycles with toggling data inside a five-zero window
    sendWindow('{50, 900, 1800, 2700, 3600}, 1'b1, "R8");
    // R6: 191 zeros then a one leave red flag low
    sendRun(1'b0, ZRUN - 1, "R6");
    sendBit(1'b1, "R6");
    // R9/R5: 192nd zero lands on the window close
    while (mWin != WIN - ZRUN) sendBit(1'b1, "R2");
    sendRun(1'b0, ZRUN, "R5");
    // R7: 13 ones keep the flag, then 14 ones clear it
    sendRun(1'b1, DMIN - 1, "R7");
    sendRun(1'b0, DLEN - DMIN + 1, "R7");
    idleCycles(4, "R8");
    sendRun(1'b1, DMIN, "R7");
    sendRun(1'b0, DLEN - DMIN, "R7");
    // finish the window, then one clean window sets blue flag again
    while (mWin != 0) sendBit(1'b1, "R2");
    sendRun(1'b1, WIN, "R3");
    idleCycles(3, "R8");
    @(negedge clk);
    @(negedge clk);
    printSummary();
    $finish;
  end

endmodule